// File: doc/BRIEF.md
# Thermistor Temperature Inhibit Controller

This block checks the battery temperature on a fixed schedule and raises charge-inhibit and discharge-inhibit flags. A free-running cycle timer switches on the thermistor driver for a short window at the start of each measurement period. The driver stays off for the rest of the period, which saves supply current. On the last clock of the window the block reads six comparator flags. Each pair of flags (one detect, one release) belongs to one of three conditions: charging while hot, charging while cold, and discharging while hot. The levels for the two hot conditions fall as temperature rises, so their comparators report "at or below". The level for the cold condition rises as temperature falls, so its comparator reports "at or above". The comparators are outside this block; only their digital results come in.

Each condition has hysteresis. It is set only from its detect flag and cleared only from its release flag. A change needs the flag on two samples in a row, which is a delay of one to two periods. A test input shortens the period and lets one sample be enough. The power-down input stops measuring and forgets any partly counted change. It also clears the two hot conditions, while the cold condition keeps its state.

Top module: `thermal_inhibit_ctrl`

## Requirements
- R1: With `testMode` low, `drvEn` rises every CYC_NORM clocks (default 40). With `testMode` high, it rises every CYC_TEST clocks (default 10).
- R2: In every period `drvEn` is high for exactly WIN_LEN consecutive clocks (default 4) and low for the rest. It is low during reset.
- R3: The comparator inputs are read only on the last clock of each driver window. Input pulses that begin and end outside the window have no effect on the outputs.
- R4: In normal mode a clear condition becomes set only after its detect input has been read high on two consecutive samples. The output changes at the clock edge that ends the window of the second sample.
- R5: In normal mode a set condition clears only after its release input has been read high on two consecutive samples. A sample with neither input high leaves the condition as it is.
- R6: One sample without the relevant input (detect while clear, release while set) cancels a pending change. The next change again needs two consecutive samples.
- R7: With `testMode` high, one sample with the relevant input high is enough to set or clear a condition.
- R8: `chgInhibit` is the OR of the hot-charge and cold-charge conditions. `dchgInhibit` follows only the hot-discharge condition.
- R9: While `powerDown` is high, `drvEn` stays low and no sample is taken. Pending changes are dropped and both hot conditions clear. The cold-charge condition keeps its state.
- R10: After reset all three conditions are clear and `chgInhibit` and `dchgInhibit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | Short period and single-sample delay |
| powerDown | input | 1 | Stop measuring, clear hot conditions |
| hotChgDet | input | 1 | Sense at or below hot-charge detect level |
| hotChgRel | input | 1 | Sense at or above hot-charge release level |
| coldChgDet | input | 1 | Sense at or above cold-charge detect level |
| coldChgRel | input | 1 | Sense at or below cold-charge release level |
| hotDchgDet | input | 1 | Sense at or below hot-discharge detect level |
| hotDchgRel | input | 1 | Sense at or above hot-discharge release level |
| drvEn | output | 1 | Thermistor driver enable |
| chgInhibit | output | 1 | Charging not allowed |
| dchgInhibit | output | 1 | Discharging not allowed |

## Verification
The embedded properties check on every cycle these points:
- the timer stays within its range;
- a sample always ends the window;
- power-down keeps the driver off;
- a condition changes only on a sample, and only in the direction its input allows;
- power-down clears the hot conditions.

The two-sample delay can only be shown by the bench's period-by-period scenarios. The same holds for cancelling a pending change, the single-sample test mode, the measured period and window lengths, the OR of the charge outputs, and the cold condition surviving power-down.

// File: rtl/tinh_pkg.sv
package tinh_pkg;
  localparam int NUM_COND     = 3;
  localparam int IDX_HOT_CHG  = 0;
  localparam int IDX_COLD_CHG = 1;
  localparam int IDX_HOT_DCHG = 2;

  typedef struct packed {
    logic sample;  // last clock of the driver window
    logic clear;   // power-down
  } tinh_strobe_t;
endpackage

// File: rtl/tinh_timer.sv
module tinh_timer
  import tinh_pkg::*;
#(
  parameter int CYC_NORM = 40,
  parameter int CYC_TEST = 10,
  parameter int WIN_LEN  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         testMode,
  input  logic         powerDown,
  output logic         drvEn,
  output tinh_strobe_t stb
);
  localparam int CW = $clog2(CYC_NORM + 1);
  localparam logic [CW-1:0] IDLE_START = CW'(WIN_LEN);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = testMode ? CW'(CYC_TEST - 1) : CW'(CYC_NORM - 1);

  // idle start point keeps the driver off right after reset or power-down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= IDLE_START;
    else if (powerDown)  cnt <= IDLE_START;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign drvEn      = !powerDown && (cnt < CW'(WIN_LEN));
  assign stb.sample = drvEn && (cnt == CW'(WIN_LEN - 1));
  assign stb.clear  = powerDown;

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CYC_NORM - 1));
  a_r2_window_ends_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    stb.sample |=> !drvEn);
  a_r9_driver_idle_after_pd: assert property (@(posedge clk) disable iff (!rst_n)
    powerDown |=> !drvEn);
endmodule

// File: rtl/tinh_cond.sv
module tinh_cond
  import tinh_pkg::*;
#(
  parameter bit CLEAR_ON_PD = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         testMode,
  input  tinh_strobe_t stb,
  input  logic         det,
  input  logic         rel,
  output logic         flag
);
  logic pend;
  logic trig;

  // a set flag listens only to release, a clear one only to detect
  assign trig = flag ? rel : det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      pend <= 1'b0;
    end else if (stb.clear) begin
      pend <= 1'b0;
      if (CLEAR_ON_PD) flag <= 1'b0;
    end else if (stb.sample) begin
      if (trig) begin
        if (pend || testMode) begin
          flag <= !flag;
          pend <= 1'b0;
        end else begin
          pend <= 1'b1;
        end
      end else begin
        pend <= 1'b0;
      end
    end
  end

  a_r3_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(stb.sample));
  a_r4_rise_needs_detect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(det));
  a_r5_fall_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flag) && !$past(stb.clear)) |-> $past(rel));
  a_r9_pd_clears_hot: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clear && CLEAR_ON_PD) |=> !flag);
endmodule

// File: rtl/tinh_datapath.sv
module tinh_datapath
  import tinh_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                testMode,
  input  tinh_strobe_t        stb,
  input  logic [NUM_COND-1:0] detVec,
  input  logic [NUM_COND-1:0] relVec,
  output logic                chgInhibit,
  output logic                dchgInhibit
);
  logic [NUM_COND-1:0] flags;

  for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
    tinh_cond #(.CLEAR_ON_PD(i != IDX_COLD_CHG)) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .testMode (testMode),
      .stb      (stb),
      .det      (detVec[i]),
      .rel      (relVec[i]),
      .flag     (flags[i])
    );
  end

  assign chgInhibit  = flags[IDX_HOT_CHG] | flags[IDX_COLD_CHG];
  assign dchgInhibit = flags[IDX_HOT_DCHG];
endmodule

// File: rtl/thermal_inhibit_ctrl.sv
module thermal_inhibit_ctrl
  import tinh_pkg::*;
#(
  parameter int CYC_NORM = 40,
  parameter int CYC_TEST = 10,
  parameter int WIN_LEN  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic testMode,
  input  logic powerDown,
  input  logic hotChgDet,
  input  logic hotChgRel,
  input  logic coldChgDet,
  input  logic coldChgRel,
  input  logic hotDchgDet,
  input  logic hotDchgRel,
  output logic drvEn,
  output logic chgInhibit,
  output logic dchgInhibit
);
  tinh_strobe_t        stb;
  logic [NUM_COND-1:0] detVec;
  logic [NUM_COND-1:0] relVec;

  always_comb begin
    detVec               = '0;
    relVec               = '0;
    detVec[IDX_HOT_CHG]  = hotChgDet;
    relVec[IDX_HOT_CHG]  = hotChgRel;
    detVec[IDX_COLD_CHG] = coldChgDet;
    relVec[IDX_COLD_CHG] = coldChgRel;
    detVec[IDX_HOT_DCHG] = hotDchgDet;
    relVec[IDX_HOT_DCHG] = hotDchgRel;
  end

  tinh_timer #(.CYC_NORM(CYC_NORM), .CYC_TEST(CYC_TEST), .WIN_LEN(WIN_LEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .testMode  (testMode),
    .powerDown (powerDown),
    .drvEn     (drvEn),
    .stb       (stb)
  );

  tinh_datapath u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .testMode    (testMode),
    .stb         (stb),
    .detVec      (detVec),
    .relVec      (relVec),
    .chgInhibit  (chgInhibit),
    .dchgInhibit (dchgInhibit)
  );
endmodule

// File: tb/thermal_inhibit_ctrl_tb.sv
module thermal_inhibit_ctrl_tb;
  localparam int CYC_NORM = 40;
  localparam int CYC_TEST = 10;
  localparam int WIN_LEN  = 4;
  localparam int NVEC     = 24;

  // fields: [8] testMode [7] hotChgDet [6] hotChgRel [5] coldChgDet [4] coldChgRel
  //         [3] hotDchgDet [2] hotDchgRel [1] expected chgInhibit [0] expected dchgInhibit
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0_000000_00, 9'b0_100000_00, 9'b0_100000_10, 9'b0_000000_10,
    9'b0_010000_10, 9'b0_000000_10, 9'b0_010000_10, 9'b0_010000_00,
    9'b0_001000_00, 9'b0_001000_10, 9'b0_000010_10, 9'b0_000010_11,
    9'b0_000100_11, 9'b0_000100_01, 9'b0_000001_01, 9'b0_000001_00,
    9'b1_100000_10, 9'b1_010000_00, 9'b1_000010_01, 9'b1_000001_00,
    9'b0_100000_00, 9'b0_000000_00, 9'b0_100000_00, 9'b0_100000_10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic testMode = 1'b0, powerDown = 1'b0;
  logic hotChgDet = 1'b0, hotChgRel = 1'b0, coldChgDet = 1'b0, coldChgRel = 1'b0;
  logic hotDchgDet = 1'b0, hotDchgRel = 1'b0;
  logic drvEn, chgInhibit, dchgInhibit;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  thermal_inhibit_ctrl #(.CYC_NORM(CYC_NORM), .CYC_TEST(CYC_TEST), .WIN_LEN(WIN_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .testMode(testMode), .powerDown(powerDown),
    .hotChgDet(hotChgDet), .hotChgRel(hotChgRel), .coldChgDet(coldChgDet),
    .coldChgRel(coldChgRel), .hotDchgDet(hotDchgDet), .hotDchgRel(hotDchgRel),
    .drvEn(drvEn), .chgInhibit(chgInhibit), .dchgInhibit(dchgInhibit)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog (R1): actual hung run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    hotChgDet = 0; hotChgRel = 0; coldChgDet = 0; coldChgRel = 0;
    hotDchgDet = 0; hotDchgRel = 0;
  endtask

  // returns at the first negedge after a window has ended
  task automatic waitSample();
    @(negedge clk);
    while (!drvEn) @(negedge clk);
    while (drvEn) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int per);
    hi = 0; per = 0;
    @(negedge clk);
    while (drvEn) @(negedge clk);
    while (!drvEn) @(negedge clk);
    while (drvEn) begin hi++; per++; @(negedge clk); end
    while (!drvEn) begin per++; @(negedge clk); end
  endtask

  initial begin
    int hi, per;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 chgInhibit in reset", chgInhibit, 0);
    chk("R10 dchgInhibit in reset", dchgInhibit, 0);
    chk("R2 drvEn in reset", drvEn, 0);
    rst_n = 1'b1;

    // R1/R2: period and window lengths
    measure(hi, per);
    chk("R2 window normal", hi, WIN_LEN);
    chk("R1 period normal", per, CYC_NORM);
    testMode = 1'b1;
    measure(hi, per);
    measure(hi, per);
    chk("R2 window test", hi, WIN_LEN);
    chk("R1 period test", per, CYC_TEST);
    testMode = 1'b0;
    waitSample();

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      logic [8:0] v;
      v = VEC[i];
      testMode = v[8];
      hotChgDet = v[7]; hotChgRel = v[6]; coldChgDet = v[5]; coldChgRel = v[4];
      hotDchgDet = v[3]; hotDchgRel = v[2];
      waitSample();
      if (i >= 20)                tag = "R6 restart";
      else if (i >= 16)           tag = "R7 test mode";
      else if (i >= 8)            tag = "R8 output mapping";
      else if (i == 5)            tag = "R6 release cancel";
      else if (i >= 3)            tag = "R5 release";
      else                        tag = "R4 detect";
      chk($sformatf("%s vec %0d chg", tag, i), chgInhibit, int'(v[1]));
      chk($sformatf("%s vec %0d dchg", tag, i), dchgInhibit, int'(v[0]));
    end

    // R9: hot conditions cleared by power-down (hot charge is set here)
    clearIns();
    testMode = 1'b1; hotDchgDet = 1'b1;
    waitSample();
    chk("R7 hot discharge set", dchgInhibit, 1);
    clearIns();
    powerDown = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R9 drvEn off in power-down", drvEn, 0);
    end
    chk("R9 hot charge cleared", chgInhibit, 0);
    chk("R9 hot discharge cleared", dchgInhibit, 0);
    powerDown = 1'b0;

    // R9: cold condition kept
    coldChgDet = 1'b1;
    waitSample();
    chk("R7 cold set", chgInhibit, 1);
    clearIns();
    powerDown = 1'b1;
    repeat (3) @(negedge clk);
    powerDown = 1'b0;
    @(negedge clk);
    chk("R9 cold kept over power-down", chgInhibit, 1);
    coldChgRel = 1'b1;
    waitSample();
    chk("R7 cold released", chgInhibit, 0);
    clearIns();

    // R3: pulses outside the window are ignored
    testMode = 1'b0;
    waitSample();
    for (int k = 0; k < 3; k++) begin
      hotChgDet = 1'b1; hotDchgDet = 1'b1;
      @(negedge clk);
      while (!drvEn) @(negedge clk);
      hotChgDet = 1'b0; hotDchgDet = 1'b0;
      while (drvEn) @(negedge clk);
      chk("R3 ignored outside window chg", chgInhibit, 0);
      chk("R3 ignored outside window dchg", dchgInhibit, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule